// File: doc/BRIEF.md
# Bidirectional I/O Port with Input-Change Interrupt

This block is an eight-pin general-purpose port register set on a simple strobe bus. Software sets a direction mask, an output latch and a small control word. The control word holds a shared pull-up switch and an interrupt enable. The pin side receives per-pin output values, output enables and pull-up requests. It returns the pad inputs, which pass through a synchronizer before the block uses them.

The upper four pins are watched for change. Each synchronized input is compared against a snapshot of the port. The snapshot is taken whenever software reads or writes the port. The comparison covers only watched pins that are currently inputs. Any difference sets a sticky flag. The flag cannot be cleared while a difference remains. A wake request always follows the flag, and an interrupt line follows it only when the interrupt enable is set. The usual use is a keypad or button bank: a key press wakes the system, and the service routine then reads the port to take a fresh snapshot and clears the flag.

Top module: `gpio_chg_port`

## Requirements
- R1: While reset is low, the registers take their reset values. After a reset edge, pin_oe is 0x00 (every pin an input), pin_out is 0x00, pin_pu is 0x00, and chg_flag, irq and wake are 0.
- R2: A write-direction strobe loads bus_wdata into the direction mask (bit=1 means input). pin_oe equals the inverted mask from the next cycle on. While rd_dir is high and rd_port is low, rd_data shows the mask in the same cycle.
- R3: A write-port strobe loads bus_wdata into the output latch, and pin_out equals the latch from the next cycle on, whatever the direction.
- R4: While rd_port is high, rd_data shows pin_in as it stood two clock edges earlier, for every pin and whatever the direction. rd_port has priority over rd_dir, and with neither strobe high rd_data is 0x00.
- R5: A write-control strobe loads bus_wdata bit 0 as the active-low pull-up switch (0 = pull-ups on; resets to 1) and bit 1 as the interrupt enable (resets to 0). pin_pu[i] is 1 exactly when the switch is 0 and pin i is an input.
- R6: When a pin among bits 7..4 is an input and its pin_in value differs from the snapshot, chg_flag rises on the third clock edge after the pin changed. A change on bits 3..0 never sets the flag.
- R7: A pin among bits 7..4 whose direction bit is 0 does not take part in the comparison, so its changes leave the flag at 0.
- R8: A flag-clear strobe with bus_wdata bit 0 equal to 0 has no effect while any mismatch remains, and the flag stays 1.
- R9: A rd_port or wr_port strobe reloads the snapshot from the synchronized inputs, which ends the mismatch. After that, a flag-clear strobe with bus_wdata bit 0 = 0 drops the flag on the next edge. A flag-clear strobe with bit 0 = 1 changes nothing.
- R10: wake equals chg_flag. irq equals chg_flag when the interrupt enable is 1, and is 0 otherwise.
- R11: After reset is released, pins that do not change raise no flag. During the first three cycles after release the snapshot follows the synchronized inputs and detection is held off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wdata | input | 8 | Write data for all write strobes |
| wr_port | input | 1 | Write output latch; also reloads snapshot |
| wr_dir | input | 1 | Write direction mask |
| wr_ctrl | input | 1 | Write control word (bit0 pull-up off, bit1 irq enable) |
| wr_flag | input | 1 | Flag-clear strobe, clears when bus_wdata[0] is 0 |
| rd_port | input | 1 | Read synchronized pins; reloads snapshot |
| rd_dir | input | 1 | Read direction mask |
| rd_data | output | 8 | Read data, combinational from the strobes |
| pin_in | input | 8 | Raw pad inputs |
| pin_out | output | 8 | Output latch value per pin |
| pin_oe | output | 8 | Output driver enable per pin |
| pin_pu | output | 8 | Weak pull-up request per pin |
| chg_flag | output | 1 | Sticky change flag |
| irq | output | 1 | Change interrupt, gated by enable |
| wake | output | 1 | Wake request, follows the flag |

## Verification
Register writes show at pin_oe, pin_out and pin_pu one edge after the strobe, so the bench samples one time unit after that edge. Read data is combinational, so it is checked within the same cycle in which the strobe is driven. A pin change shows on rd_data after two edges, and it sets the flag on the third edge. The bench checks both sides of each latency: it confirms the old value, or a low flag, one edge early, and then the new value exactly on time. Flag clears are checked one edge after the strobe, both while a mismatch is held and after a snapshot reload.

// File: rtl/gpio_chg_pkg.sv
// Package: shared control-word layout and read-select type for the port.
// Assumes: control bits sit at fixed positions in the written data word.
package gpio_chg_pkg;

    localparam int CTRL_PU_OFF_BIT = 0;
    localparam int CTRL_IE_BIT     = 1;
    localparam int FLAG_CLR_BIT    = 0;

    typedef struct packed {
        logic ie;      // interrupt line enable
        logic pu_off;  // active-low pull-up switch: 1 = pull-ups off
    } port_ctrl_t;

    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_PORT = 2'd1,
        RSEL_DIR  = 2'd2
    } rd_sel_e;

endpackage

// File: rtl/gpio_sync.sv
// Module: multi-stage synchronizer for a bus of asynchronous pad inputs.
// Assumes: each bit is independent; stages reset to zero, so the consumer
// must ignore the output until STAGES edges after reset release.
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Capture the raw pad value.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d;
            end
        end else begin : g_next
            // Pass the value along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
// Module: direction mask, output latch, control word, read mux and
// pull-up gating for the port.
// Assumes: strobes last one cycle; read data is combinational.
module gpio_port_regs
    import gpio_chg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wdata,
    input  logic         wr_port,
    input  logic         wr_dir,
    input  logic         wr_ctrl,
    input  logic         rd_port,
    input  logic         rd_dir,
    input  logic [W-1:0] in_sync,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] latch_q,
    output logic         ie,
    output logic [W-1:0] pu_req,
    output logic [W-1:0] rd_data
);

    port_ctrl_t ctrl_q;
    rd_sel_e    rsel;

    // Direction mask: 1 = input, resets to all inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '1;
        else if (wr_dir) dir_q <= wdata;
    end

    // Output data latch, resets to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)       latch_q <= '0;
        else if (wr_port) latch_q <= wdata;
    end

    // Control word: pull-ups off and interrupt disabled at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.pu_off <= 1'b1;
            ctrl_q.ie     <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_q.pu_off <= wdata[CTRL_PU_OFF_BIT];
            ctrl_q.ie     <= wdata[CTRL_IE_BIT];
        end
    end

    // Read select, port read has priority.
    always_comb begin
        if (rd_port)     rsel = RSEL_PORT;
        else if (rd_dir) rsel = RSEL_DIR;
        else             rsel = RSEL_NONE;
    end

    // Read data mux.
    always_comb begin
        unique case (rsel)
            RSEL_PORT: rd_data = in_sync;
            RSEL_DIR:  rd_data = dir_q;
            default:   rd_data = '0;
        endcase
    end

    // Pull-up only on input pins while the shared switch is on.
    always_comb begin
        pu_req = ctrl_q.pu_off ? '0 : dir_q;
    end

    assign ie = ctrl_q.ie;

endmodule

// File: rtl/gpio_chg_detect.sv
// Module: snapshot register, priming window, per-pin mismatch and sticky
// change flag for the watched upper pins.
// Assumes: in_sync is valid SYNC_STAGES edges after reset release.
module gpio_chg_detect #(
    parameter int W           = 8,
    parameter int CHG_LSB     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_sync,
    input  logic [W-1:0] dir_q,
    input  logic         reload,
    input  logic         clr_req,
    output logic [W-1:0] snap_q,
    output logic         pending,
    output logic         flag
);

    localparam logic [W-1:0] CHG_MASK  = {W{1'b1}} << CHG_LSB;
    localparam int           PRIME_CYC = SYNC_STAGES + 1;
    localparam int           CW        = $clog2(PRIME_CYC + 1);

    logic [CW-1:0] prime_cnt;
    logic          primed;
    logic [W-1:0]  diff;

    assign primed = (prime_cnt == CW'(PRIME_CYC));

    // Count the priming window after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n)       prime_cnt <= '0;
        else if (!primed) prime_cnt <= prime_cnt + 1'b1;
    end

    // Snapshot follows inputs while priming, then reloads on port access.
    always_ff @(posedge clk) begin
        if (!rst_n)                  snap_q <= '0;
        else if (!primed || reload)  snap_q <= in_sync;
    end

    // Per-pin mismatch on watched input pins.
    always_comb begin
        diff    = (in_sync ^ snap_q) & dir_q & CHG_MASK;
        pending = primed && (|diff);
    end

    // Sticky flag: a mismatch sets it and beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (pending) flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

endmodule

// File: rtl/gpio_chg_port.sv
// Module: top of the I/O port: synchronizer, register file and change
// detector, with pin-side outputs and interrupt/wake lines.
// Assumes: one clock domain for the bus; pads are asynchronous.
module gpio_chg_port
    import gpio_chg_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int CHG_LSB     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic             wr_port,
    input  logic             wr_dir,
    input  logic             wr_ctrl,
    input  logic             wr_flag,
    input  logic             rd_port,
    input  logic             rd_dir,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_pu,
    output logic             chg_flag,
    output logic             irq,
    output logic             wake
);

    logic [WIDTH-1:0] in_sync_w;
    logic [WIDTH-1:0] dir_w;
    logic [WIDTH-1:0] latch_w;
    logic [WIDTH-1:0] snap_w;
    logic             ie_w;
    logic             pend_w;
    logic             clr_w;

    gpio_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (in_sync_w)
    );

    gpio_port_regs #(.W(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wdata   (bus_wdata),
        .wr_port (wr_port),
        .wr_dir  (wr_dir),
        .wr_ctrl (wr_ctrl),
        .rd_port (rd_port),
        .rd_dir  (rd_dir),
        .in_sync (in_sync_w),
        .dir_q   (dir_w),
        .latch_q (latch_w),
        .ie      (ie_w),
        .pu_req  (pin_pu),
        .rd_data (rd_data)
    );

    // Clear request only when the written clear bit is zero.
    assign clr_w = wr_flag && !bus_wdata[FLAG_CLR_BIT];

    gpio_chg_detect #(
        .W           (WIDTH),
        .CHG_LSB     (CHG_LSB),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_sync (in_sync_w),
        .dir_q   (dir_w),
        .reload  (rd_port || wr_port),
        .clr_req (clr_w),
        .snap_q  (snap_w),
        .pending (pend_w),
        .flag    (chg_flag)
    );

    assign pin_out = latch_w;
    assign pin_oe  = ~dir_w;
    assign irq     = chg_flag && ie_w;
    assign wake    = chg_flag;

endmodule

// File: rtl/gpio_chg_port_chk.sv
// Module: assertion checker for the I/O port, bound into every instance.
// Assumes: synchronous active-low reset; one-cycle strobes.
module gpio_chg_port_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] bus_wdata,
    input logic         wr_port,
    input logic         wr_dir,
    input logic         wr_flag,
    input logic         rd_port,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] pin_oe,
    input logic [W-1:0] pin_pu,
    input logic         chg_flag,
    input logic         irq,
    input logic         wake,
    input logic         pending,
    input logic [W-1:0] snap,
    input logic [W-1:0] in_sync
);

    // R1
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_out == '0 && pin_pu == '0 && !chg_flag));

    // R2
    dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> pin_oe == ~$past(bus_wdata));

    // R3
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_port |=> pin_out == $past(bus_wdata));

    // R5
    pu_on_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0);

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> chg_flag);

    // R8
    clr_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && !bus_wdata[0] && pending) |=> chg_flag);

    // R9
    snap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_port || wr_port) |=> snap == $past(in_sync));

    // R9
    clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && !bus_wdata[0] && !pending) |=> !chg_flag);

    // R10
    irq_needs_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> wake);

endmodule

bind gpio_chg_port gpio_chg_port_chk #(.W(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wdata (bus_wdata),
    .wr_port   (wr_port),
    .wr_dir    (wr_dir),
    .wr_flag   (wr_flag),
    .rd_port   (rd_port),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pin_pu    (pin_pu),
    .chg_flag  (chg_flag),
    .irq       (irq),
    .wake      (wake),
    .pending   (pend_w),
    .snap      (snap_w),
    .in_sync   (in_sync_w)
);

// File: tb/tb_gpio_chg_port.sv
// Bench: sweeps direction, latch, input and pull-up values exhaustively and
// walks a change across every pin, with expected values computed here.
module tb_gpio_chg_port;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] bus_wdata;
    logic       wr_port, wr_dir, wr_ctrl, wr_flag, rd_port, rd_dir;
    logic [7:0] rd_data, pin_in, pin_out, pin_oe, pin_pu;
    logic       chg_flag, irq, wake;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    gpio_chg_port dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wdata (bus_wdata),
        .wr_port   (wr_port),
        .wr_dir    (wr_dir),
        .wr_ctrl   (wr_ctrl),
        .wr_flag   (wr_flag),
        .rd_port   (rd_port),
        .rd_dir    (rd_dir),
        .rd_data   (rd_data),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pin_pu    (pin_pu),
        .chg_flag  (chg_flag),
        .irq       (irq),
        .wake      (wake)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input int which, input logic [7:0] v);
        bus_wdata = v;
        case (which)
            0: wr_port = 1'b1;
            1: wr_dir  = 1'b1;
            2: wr_ctrl = 1'b1;
            default: wr_flag = 1'b1;
        endcase
        step(1);
        wr_port = 1'b0; wr_dir = 1'b0; wr_ctrl = 1'b0; wr_flag = 1'b0;
    endtask

    task automatic rd_pulse();
        rd_port = 1'b1;
        step(1);
        rd_port = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_wdata = '0; pin_in = 8'hA5;
        wr_port = 0; wr_dir = 0; wr_ctrl = 0; wr_flag = 0; rd_port = 0; rd_dir = 0;
        step(3);
        // R1 reset values
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 pin_out", pin_out, 8'h00);
        chk("R1 pin_pu", pin_pu, 8'h00);
        chk("R1 flag/irq/wake", {5'b0, chg_flag, irq, wake}, 8'h00);
        rst_n = 1'b1;
        step(8);
        // R11 static pins after reset raise nothing
        chk("R11 flag after reset", {7'b0, chg_flag}, 8'h00);
        rd_dir = 1'b1; #1;
        chk("R2 reset dir readback", rd_data, 8'hFF);
        rd_dir = 1'b0; #1;
        chk("R4 idle read", rd_data, 8'h00);

        // R2 direction sweep
        for (int v = 0; v < 256; v++) begin
            wr(1, 8'(v));
            chk("R2 pin_oe", pin_oe, ~8'(v));
            rd_dir = 1'b1; #1;
            chk("R2 rd_dir", rd_data, 8'(v));
            rd_dir = 1'b0;
        end

        // R3 latch sweep, direction left all inputs
        wr(1, 8'hFF);
        for (int v = 0; v < 256; v++) begin
            wr(0, 8'(v));
            chk("R3 pin_out", pin_out, 8'(v));
        end

        // R4 input sweep with all outputs, rd_port beats rd_dir
        wr(1, 8'h00);
        pin_in = 8'h00;
        step(3);
        rd_port = 1'b1; rd_dir = 1'b1;
        for (int v = 1; v < 256; v++) begin
            pin_in = 8'(v);
            step(1);
            chk("R4 one edge early", rd_data, 8'(v - 1));
            step(1);
            chk("R4 two edges", rd_data, 8'(v));
        end
        rd_port = 1'b0; rd_dir = 1'b0;

        // R5 pull-up gating over all directions
        for (int pu = 0; pu < 2; pu++) begin
            wr(2, {6'b0, 1'b0, pu == 1 ? 1'b0 : 1'b1});
            for (int v = 0; v < 256; v++) begin
                wr(1, 8'(v));
                chk("R5 pin_pu", pin_pu, pu == 1 ? 8'(v) : 8'h00);
            end
        end
        wr(2, 8'h01);

        // Prepare change detection: all inputs, pins low, fresh snapshot
        wr(1, 8'hFF);
        pin_in = 8'h00;
        step(3);
        rd_pulse();
        wr(3, 8'h00);
        chk("R9 cleared before walk", {7'b0, chg_flag}, 8'h00);

        // R6 walk a change over every pin
        for (int i = 0; i < 8; i++) begin
            pin_in = 8'(1 << i);
            step(2);
            chk("R6 flag not yet", {7'b0, chg_flag}, 8'h00);
            step(1);
            chk("R6 flag on third edge", {7'b0, chg_flag}, (i >= 4) ? 8'h01 : 8'h00);
            chk("R10 wake follows", {7'b0, wake}, (i >= 4) ? 8'h01 : 8'h00);
            chk("R10 irq disabled", {7'b0, irq}, 8'h00);
            pin_in = 8'h00;
            step(3);
            wr(3, 8'h00);
            chk("R9 clear after match", {7'b0, chg_flag}, 8'h00);
        end

        // R7 upper pins as outputs are excluded
        wr(1, 8'h0F);
        pin_in = 8'hF0;
        step(5);
        chk("R7 output pins ignored", {7'b0, chg_flag}, 8'h00);
        pin_in = 8'h00;
        step(3);

        // R8 clear blocked while mismatch held; R10 irq enable
        wr(1, 8'hFF);
        pin_in = 8'h20;
        step(3);
        chk("R8 flag set", {7'b0, chg_flag}, 8'h01);
        wr(3, 8'h00);
        chk("R8 clear ignored", {7'b0, chg_flag}, 8'h01);
        chk("R10 irq off", {7'b0, irq}, 8'h00);
        wr(2, 8'h03);
        chk("R10 irq on", {7'b0, irq}, 8'h01);
        chk("R10 wake", {7'b0, wake}, 8'h01);

        // R9 read reloads snapshot; writing 1 does not clear
        rd_pulse();
        wr(3, 8'h01);
        chk("R9 clear bit one ignored", {7'b0, chg_flag}, 8'h01);
        wr(3, 8'h00);
        chk("R9 clear after read", {7'b0, chg_flag}, 8'h00);
        chk("R10 irq drops", {6'b0, irq, wake}, 8'h00);

        // R9 port write also reloads snapshot
        pin_in = 8'h60;
        step(3);
        chk("R6 second change", {7'b0, chg_flag}, 8'h01);
        wr(0, 8'h5A);
        wr(3, 8'h00);
        chk("R9 clear after write", {7'b0, chg_flag}, 8'h00);
        chk("R3 latch after reload write", pin_out, 8'h5A);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule